// File: doc/BRIEF.md
# Audio Bit and Frame Clock Divider

This block turns an audio master clock into two slower clock levels for a serial audio link. The first is a bit clock at one half or one quarter of the master rate. The second is a left/right frame clock at 1/32, 1/64 or 1/128 of the bit clock. Both outputs are registered levels in the master clock domain. A 32-bit control word enables them, selects both divide ratios, and chooses whether the frame clock moves on the rising or the falling bit clock edge.

A small state machine follows the control word. It has three states. `ST_IDLE` means the block is disabled. `ST_RUN` means both dividers count. `ST_HOLD` means the frame code is invalid, so the bit clock keeps running while the frame clock holds its level.

The transitions are:
- `T_ENABLE`: IDLE→RUN, when the enable bit sets with a valid frame code.
- `T_ENABLE_BAD`: IDLE→HOLD, when the enable bit sets with code 3.
- `T_BADCODE`: RUN→HOLD.
- `T_GOODCODE`: HOLD→RUN.
- `T_DISABLE`: any state→IDLE, when the enable bit clears.

The dividers act on the next state, so a control change takes effect at the first master edge that samples it.

Top module: `audio_clkdiv`

## Requirements
- R1: With control bit 16 at 0, the bit clock toggles on every master edge while the block is enabled. It goes high on the first edge after the enable is sampled.
- R2: With control bit 16 at 1, the bit clock toggles on every second master edge. The first high level comes two edges after the enable is sampled.
- R3: Control bits [18:17] set the frame period, counted in bit clock periods: code 0 gives 32, code 1 gives 64, code 2 gives 128.
- R4: The frame clock has a 50% duty cycle. It starts low after enable, and goes high after half the selected count of active bit clock edges.
- R5: With control bit 19 at 0, the frame clock changes only on the master edge where the bit clock rises.
- R6: With control bit 19 at 1, the frame clock changes only on the master edge where the bit clock falls.
- R7: Frame code 3 stops the frame clock at its present level, while the bit clock continues to toggle.
- R8: With control bit 31 at 0, both outputs are low after the next master edge and both counters restart. A later enable repeats the waveform of R1 to R6 from its start.
- R9: While reset is asserted (rst_ni low), both outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Audio master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 32 | Control word: bit 31 enable, bit 19 frame edge polarity, bits [18:17] frame divide code, bit 16 bit clock divide select |
| bclk_o | output | 1 | Serial bit clock level |
| frame_o | output | 1 | Left/right frame clock level |

## Verification
Each output is one register stage from the control word. A control value applied between edges therefore shows on the outputs right after the next master edge. After n edges with the block enabled, the bench computes the expected bit clock from n and the bit clock divide. It then counts the selected bit clock edges to get the expected frame level. The bench drives inputs on the falling master edge and samples after each rising edge, so every comparison sees the value that edge produced. The hold and disable cases are judged on the first sample after the control change.

// File: rtl/audclk_pkg.sv
package audclk_pkg;
    localparam int CTRL_W   = 32;
    localparam int EN_BIT   = 31;
    localparam int POL_BIT  = 19;
    localparam int FSEL_LSB = 17;
    localparam int BSEL_BIT = 16;

    localparam logic [1:0] FCODE_BAD = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_HOLD = 2'd2
    } run_state_e;
endpackage

// File: rtl/audclk_ctrl_fsm.sv
module audclk_ctrl_fsm
    import audclk_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       en_i,
    input  logic [1:0] fcode_i,
    output run_state_e state_q,
    output run_state_e state_d,
    output logic       bclk_run_o,
    output logic       frame_run_o
);
    logic code_ok;
    assign code_ok = (fcode_i != FCODE_BAD);

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (en_i && code_ok)  state_d = ST_RUN;   // T_ENABLE
                else if (en_i)        state_d = ST_HOLD;  // T_ENABLE_BAD
            end
            ST_RUN: begin
                if (!en_i)            state_d = ST_IDLE;  // T_DISABLE
                else if (!code_ok)    state_d = ST_HOLD;  // T_BADCODE
            end
            ST_HOLD: begin
                if (!en_i)            state_d = ST_IDLE;  // T_DISABLE
                else if (code_ok)     state_d = ST_RUN;   // T_GOODCODE
            end
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // outputs, taken from the next state so control acts at this edge
    always_comb begin
        bclk_run_o  = 1'b0;
        frame_run_o = 1'b0;
        unique case (state_d)
            ST_RUN:  begin bclk_run_o = 1'b1; frame_run_o = 1'b1; end
            ST_HOLD: begin bclk_run_o = 1'b1; frame_run_o = 1'b0; end
            default: begin bclk_run_o = 1'b0; frame_run_o = 1'b0; end
        endcase
    end
endmodule

// File: rtl/audclk_bclk_gen.sv
module audclk_bclk_gen #(
    parameter int DIV_LO = 2,
    parameter int DIV_HI = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic run_i,
    input  logic sel_hi_i,
    output logic bclk_q,
    output logic rise_o,
    output logic fall_o
);
    localparam int HALF_LO = DIV_LO / 2;
    localparam int HALF_HI = DIV_HI / 2;
    localparam int CNT_W   = $clog2(HALF_HI + 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             toggle;

    assign last   = sel_hi_i ? CNT_W'(HALF_HI - 1) : CNT_W'(HALF_LO - 1);
    assign toggle = run_i && (cnt_q >= last);
    assign rise_o = toggle && !bclk_q;
    assign fall_o = toggle &&  bclk_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (!run_i) begin
            cnt_q  <= '0;
            bclk_q <= 1'b0;
        end else if (toggle) begin
            cnt_q  <= '0;
            bclk_q <= !bclk_q;
        end else begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/audclk_frame_gen.sv
module audclk_frame_gen #(
    parameter int FRAME_MIN = 32,
    parameter int NCODES    = 3
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       active_i,
    input  logic       count_i,
    input  logic       pol_fall_i,
    input  logic [1:0] code_i,
    input  logic       rise_i,
    input  logic       fall_i,
    output logic       frame_q
);
    localparam int HALF_MAX = (FRAME_MIN << (NCODES - 1)) / 2;
    localparam int CNT_W    = $clog2(HALF_MAX);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             step;
    int               last_int;

    always_comb begin
        last_int = ((FRAME_MIN / 2) << code_i) - 1;
        last     = CNT_W'(last_int);
    end

    assign step = count_i && (pol_fall_i ? fall_i : rise_i);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q   <= '0;
            frame_q <= 1'b0;
        end else if (!active_i) begin
            cnt_q   <= '0;
            frame_q <= 1'b0;
        end else if (step) begin
            if (cnt_q >= last) begin
                cnt_q   <= '0;
                frame_q <= !frame_q;
            end else begin
                cnt_q   <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/audio_clkdiv.sv
module audio_clkdiv
    import audclk_pkg::*;
#(
    parameter int DIV_LO    = 2,
    parameter int DIV_HI    = 4,
    parameter int FRAME_MIN = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [CTRL_W-1:0] ctrl_i,
    output logic              bclk_o,
    output logic              frame_o
);
    run_state_e state_q;
    run_state_e state_d;
    logic       bclk_run;
    logic       frame_run;
    logic       rise;
    logic       fall;
    logic [1:0] fcode;
    logic       unused_ctrl;

    assign fcode       = ctrl_i[FSEL_LSB +: 2];
    assign unused_ctrl = ^{ctrl_i[30:20], ctrl_i[15:0]};

    audclk_ctrl_fsm u_fsm (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .en_i        (ctrl_i[EN_BIT]),
        .fcode_i     (fcode),
        .state_q     (state_q),
        .state_d     (state_d),
        .bclk_run_o  (bclk_run),
        .frame_run_o (frame_run)
    );

    audclk_bclk_gen #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_bclk (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (bclk_run),
        .sel_hi_i (ctrl_i[BSEL_BIT]),
        .bclk_q   (bclk_o),
        .rise_o   (rise),
        .fall_o   (fall)
    );

    audclk_frame_gen #(.FRAME_MIN(FRAME_MIN), .NCODES(3)) u_frame (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .active_i   (bclk_run),
        .count_i    (frame_run),
        .pol_fall_i (ctrl_i[POL_BIT]),
        .code_i     (fcode),
        .rise_i     (rise),
        .fall_i     (fall),
        .frame_q    (frame_o)
    );
endmodule

// File: rtl/audio_clkdiv_chk.sv
module audio_clkdiv_chk
    import audclk_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic [CTRL_W-1:0] ctrl_i,
    input logic              bclk_o,
    input logic              frame_o,
    input run_state_e        state_q
);
    // R1: fast divide toggles the bit clock on every enabled edge
    a_r1_fast_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) && !$past(ctrl_i[BSEL_BIT]) |-> (bclk_o != $past(bclk_o)));

    // R8: disabled state drives both outputs low
    a_r8_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE) |-> (!bclk_o && !frame_o));

    // R7: invalid frame code freezes the frame clock
    a_r7_hold_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_HOLD) |-> $stable(frame_o));

    // R5 and R6: frame moves only with the selected bit clock edge
    a_r5_frame_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_RUN) && (frame_o != $past(frame_o))
        |-> (bclk_o != $past(bclk_o)) && (bclk_o == !$past(ctrl_i[POL_BIT])));
endmodule

bind audio_clkdiv audio_clkdiv_chk u_chk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .ctrl_i  (ctrl_i),
    .bclk_o  (bclk_o),
    .frame_o (frame_o),
    .state_q (state_q)
);

// File: tb/audio_clkdiv_bench.sv
module audio_clkdiv_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] ctrl = 32'h0;
    logic        bclk;
    logic        frame;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #5 clk = !clk;

    audio_clkdiv u_audio_clkdiv (
        .clk_i   (clk),
        .rst_ni  (rst_n),
        .ctrl_i  (ctrl),
        .bclk_o  (bclk),
        .frame_o (frame)
    );

    localparam int NVEC = 8;
    localparam logic [31:0] VEC_CTRL [NVEC] = '{
        32'h8000_0000, 32'h8008_0000, 32'h8001_0000, 32'h800B_0000,
        32'h8002_0000, 32'h800C_0000, 32'h8005_0000, 32'h800D_0000};
    localparam int VEC_LEN [NVEC] = '{140, 140, 280, 520, 280, 520, 1040, 1040};

    // expected {bclk, frame} after n enabled edges, from the requirements
    function automatic logic [1:0] model(input logic [31:0] c, input int n);
        int h, j, s, half;
        h    = c[16] ? 2 : 1;
        j    = n / h;
        s    = c[19] ? (j / 2) : ((j + 1) / 2);
        half = 16 << c[18:17];
        return {1'(j % 2), 1'((s / half) % 2)};
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [1:0] e;
        logic       held;
        logic       prev_b;
        bit         ok_b;
        bit         ok_f;
        int         ab, af, eb, ef;

        // R9: reset
        repeat (3) @(negedge clk);
        check(!bclk && !frame, "R9 reset low", {bclk, frame}, 0);
        ctrl = 32'h8000_0000;
        tick();
        check(!bclk && !frame, "R9 reset overrides enable", {bclk, frame}, 0);
        ctrl = 32'h0;
        rst_n = 1'b1;
        tick();

        // vector table
        for (int v = 0; v < NVEC; v++) begin
            ctrl = 32'h0;
            tick();
            check(!bclk && !frame, "R8 disabled low", {bclk, frame}, 0);
            ctrl = VEC_CTRL[v];
            ok_b = 1; ok_f = 1; ab = 0; af = 0; eb = 0; ef = 0;
            for (int n = 1; n <= VEC_LEN[v]; n++) begin
                tick();
                e = model(VEC_CTRL[v], n);
                if (ok_b && bclk != e[1]) begin ok_b = 0; ab = bclk; eb = e[1]; end
                if (ok_f && frame != e[0]) begin ok_f = 0; af = frame; ef = e[0]; end
            end
            if (VEC_CTRL[v][16]) check(ok_b, "R2 bit clock div4", ab, eb);
            else                 check(ok_b, "R1 bit clock div2", ab, eb);
            if (VEC_CTRL[v][19]) check(ok_f, "R3 R4 R6 frame on falling", af, ef);
            else                 check(ok_f, "R3 R4 R5 frame on rising", af, ef);
        end

        // R7: invalid code holds frame, bit clock continues
        ctrl = 32'h0;
        tick();
        ctrl = 32'h8000_0000;
        repeat (40) tick();
        check(frame == 1'b1, "R4 frame high after 40 edges", frame, 1);
        held = frame;
        prev_b = bclk;
        ctrl = 32'h8006_0000;
        ok_b = 1; ok_f = 1;
        for (int n = 0; n < 200; n++) begin
            tick();
            if (frame != held) ok_f = 0;
            if (bclk == prev_b) ok_b = 0;
            prev_b = bclk;
        end
        check(ok_f, "R7 frame held", frame, held);
        check(ok_b, "R7 bit clock keeps toggling", ok_b, 1);

        // R8: disable mid-frame then restart from the beginning
        ctrl = 32'h8000_0000;
        repeat (10) tick();
        ctrl = 32'h0;
        tick();
        check(!bclk && !frame, "R8 low one edge after disable", {bclk, frame}, 0);
        ctrl = 32'h8001_0000;
        ok_b = 1; ab = 0; eb = 0;
        for (int n = 1; n <= 200; n++) begin
            tick();
            e = model(32'h8001_0000, n);
            if (ok_b && {bclk, frame} != e) begin ok_b = 0; ab = {bclk, frame}; eb = e; end
        end
        check(ok_b, "R8 restart from start", ab, eb);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule